// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Alarm

This block keeps wall-clock time for a chip. Seconds, minutes and hours are held in packed BCD. A binary day counter of `DAY_W` bits sits beside them, and software reads it as two byte registers. Counting is paced by a `tick` input that pulses `TICKS_PER_SEC` times per second. A sub-second phase counter turns those pulses into one-second steps. Software reaches every field through a small byte-wide register port: a 4-bit address, write data, a write strobe and combinational read data.

The alarm compares minute, hour and day. Each of the three comparisons has its own enable. When seconds roll to 00 and every enabled field equals the new time, a sticky flag is set, and `irq` is driven while that flag and the interrupt enable are both set.

A small sequencer orders the two sources of change, the one-second update and the register writes. It has three named states:

- **ST_IDLE**: writes apply directly.
- **ST_APPLY**: the one-cycle update, during which the busy bit reads 1.
- **ST_REPLAY**: a write that arrived during ST_APPLY is applied here.

Its transitions are:

- **GO_UPDATE**: ST_IDLE to ST_APPLY, when a second is due and no time write is applied in that cycle.
- **UPDATE_DONE**: ST_APPLY to ST_IDLE, with no write pending.
- **DEFER_WRITE**: ST_APPLY to ST_REPLAY, when a write arrives.
- **REPLAY_MORE**: ST_REPLAY to ST_REPLAY, when another write arrives.
- **REPLAY_DONE**: ST_REPLAY to ST_IDLE.

Top module: `bcd_rtc`

## Requirements
- R1: Seconds (address 1) and minutes (address 2) count in packed BCD from 0x00 to 0x59. Seconds go from 0x59 to 0x00 and carry into minutes; minutes go from 0x59 to 0x00 and carry into hours.
- R2: Hours (address 3) count in packed BCD from 0x00 to 0x23. A step from 0x23 to 0x00 increments the day counter.
- R3: The day counter is a 15-bit binary count. Its bits 7:0 are at address 4 and its bits 14:8 are at address 5, where bit 7 reads 0. It carries from the low byte into the high byte and wraps from 0x7FFF to 0.
- R4: With run (control bit 0) set, seconds advance once per `TICKS_PER_SEC` tick pulses. With run clear, ticks are ignored and the time holds.
- R5: A write to any of addresses 1 to 5 restarts the sub-second phase. The next advance needs a full `TICKS_PER_SEC` ticks after that write.
- R6: Control bit 7 is a read-only busy bit. If the completing tick is sampled at edge E, the bit is 1 for exactly the cycle between edges E+1 and E+2, and the time fields take their new value at edge E+2.
- R7: A write presented during the busy cycle is not lost. It is applied one cycle later, after the update, so the written value is what remains.
- R8: The alarm flag (control bit 5) is set when seconds roll to 0x00 and every enabled field equals the new time. The enables are minute (control bit 1), hour (control bit 2) and day (control bit 3). Alarm minute, hour, day low and day high are at addresses 6, 7, 8 and 9. A disabled field is ignored, and no flag is set on a step that does not roll seconds to 0x00.
- R9: The alarm flag is sticky. Writing 1 to control bit 5 clears it, and writing 0 there leaves it unchanged. `irq` equals the flag AND the interrupt enable (control bit 4).
- R10: After reset every register reads 0 and `irq` is 0. Control bit 6 and addresses 10 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sub-second pacing pulse |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the register at `addr` |
| irq | output | 1 | Alarm interrupt |

## Verification
The one-second update and a register write can land in the same cycle. The bench provokes this by holding the write strobe high exactly in the cycle where the busy bit reads 1. In one case it writes minutes while seconds roll 0x59 to 0x00, which also carries into minutes. The result is judged by reading back the written minute value rather than the carried one, and by seeing seconds at 0x00. A lost write or a reversed order shows a different value.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_APPLY  = 2'd1,
        ST_REPLAY = 2'd2
    } seq_state_t;

    localparam logic [3:0] A_CTRL   = 4'd0;
    localparam logic [3:0] A_SEC    = 4'd1;
    localparam logic [3:0] A_MIN    = 4'd2;
    localparam logic [3:0] A_HOUR   = 4'd3;
    localparam logic [3:0] A_DAYLO  = 4'd4;
    localparam logic [3:0] A_DAYHI  = 4'd5;
    localparam logic [3:0] A_AMIN   = 4'd6;
    localparam logic [3:0] A_AHOUR  = 4'd7;
    localparam logic [3:0] A_ADAYLO = 4'd8;
    localparam logic [3:0] A_ADAYHI = 4'd9;

    function automatic logic is_time_addr(input logic [3:0] a);
        return (a >= A_SEC) && (a <= A_DAYHI);
    endfunction

endpackage

// File: rtl/bcd_rtc_inc.sv
module bcd_rtc_inc #(
    parameter logic [7:0] LAST = 8'h59
) (
    input  logic [7:0] cur,
    output logic [7:0] nxt,
    output logic       wrap
);
    always_comb begin
        wrap = (cur == LAST);
        if (wrap)
            nxt = 8'h00;
        else if (cur[3:0] == 4'd9)
            nxt = {cur[7:4] + 4'd1, 4'd0};
        else
            nxt = {cur[7:4], cur[3:0] + 4'd1};
    end
endmodule

// File: rtl/bcd_rtc_match.sv
module bcd_rtc_match #(
    parameter int DAY_W = 15
) (
    input  logic [7:0]       new_min,
    input  logic [7:0]       new_hour,
    input  logic [DAY_W-1:0] new_day,
    input  logic [7:0]       al_min,
    input  logic [7:0]       al_hour,
    input  logic [DAY_W-1:0] al_day,
    input  logic             en_min,
    input  logic             en_hour,
    input  logic             en_day,
    output logic             hit
);
    always_comb begin
        hit = (!en_min  || (new_min  == al_min))  &&
              (!en_hour || (new_hour == al_hour)) &&
              (!en_day  || (new_day  == al_day));
    end
endmodule

// File: rtl/bcd_rtc_seq.sv
module bcd_rtc_seq
    import bcd_rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic       busy,
    output logic       wr_go,
    output logic [3:0] wr_addr,
    output logic [7:0] wr_data
);
    localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(TICKS_PER_SEC - 1);

    seq_state_t    state, state_n;
    logic [PW-1:0] phase;
    logic          sec_due;
    logic [3:0]    pend_addr;
    logic [7:0]    pend_data;
    logic          wrap, time_hit;

    assign wrap     = tick && run && (phase == PH_LAST);
    assign time_hit = wr_go && is_time_addr(wr_addr);

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (sec_due && !(wr_en && is_time_addr(addr))) state_n = ST_APPLY;
            ST_APPLY:  state_n = wr_en ? ST_REPLAY : ST_IDLE;
            ST_REPLAY: state_n = wr_en ? ST_REPLAY : ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        wr_go   = 1'b0;
        wr_addr = pend_addr;
        wr_data = pend_data;
        unique case (state)
            ST_IDLE: begin
                wr_go   = wr_en;
                wr_addr = addr;
                wr_data = wdata;
            end
            ST_APPLY:  busy  = 1'b1;
            ST_REPLAY: wr_go = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= '0;
            sec_due   <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
        end else begin
            if (time_hit)
                phase <= '0;
            else if (tick && run)
                phase <= wrap ? '0 : phase + 1'b1;

            if (time_hit)
                sec_due <= 1'b0;
            else if (wrap)
                sec_due <= 1'b1;
            else if (state == ST_APPLY)
                sec_due <= 1'b0;

            if (wr_en && state != ST_IDLE) begin
                pend_addr <= addr;
                pend_data <= wdata;
            end
        end
    end

    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy) else $error("busy longer than one cycle"); // R6
    AST_NO_WR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_go) else $error("write applied during update"); // R7
    AST_DEFER_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> wr_go) else $error("deferred write lost"); // R7
    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        time_hit |=> (phase == '0)) else $error("phase not restarted"); // R5
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import bcd_rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 4,
    parameter int DAY_W         = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);
    logic [7:0]       sec, mins, hour, al_min, al_hour;
    logic [DAY_W-1:0] day, al_day;
    logic             run, en_min, en_hour, en_day, ien, flag;
    logic             busy, wr_go;
    logic [3:0]       wr_addr;
    logic [7:0]       wr_data;
    logic [7:0]       sec_n, min_n, hour_n;
    logic             sec_wrap, min_wrap, hour_wrap, hit;
    logic [DAY_W-1:0] day_n;
    logic [15:0]      day16, al_day16;

    bcd_rtc_seq #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
        .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy(busy), .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    bcd_rtc_inc #(.LAST(8'h59)) u_inc_sec  (.cur(sec),  .nxt(sec_n),  .wrap(sec_wrap));
    bcd_rtc_inc #(.LAST(8'h59)) u_inc_min  (.cur(mins), .nxt(min_n),  .wrap(min_wrap));
    bcd_rtc_inc #(.LAST(8'h23)) u_inc_hour (.cur(hour), .nxt(hour_n), .wrap(hour_wrap));

    assign day_n = day + 1'b1;

    // compared only on a seconds rollover, so minutes always step there
    bcd_rtc_match #(.DAY_W(DAY_W)) u_match (
        .new_min(min_n),
        .new_hour(min_wrap ? hour_n : hour),
        .new_day((min_wrap && hour_wrap) ? day_n : day),
        .al_min(al_min), .al_hour(al_hour), .al_day(al_day),
        .en_min(en_min), .en_hour(en_hour), .en_day(en_day),
        .hit(hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec <= '0; mins <= '0; hour <= '0; day <= '0;
            al_min <= '0; al_hour <= '0; al_day <= '0;
            run <= 1'b0; en_min <= 1'b0; en_hour <= 1'b0; en_day <= 1'b0;
            ien <= 1'b0; flag <= 1'b0;
        end else if (busy) begin
            sec <= sec_n;
            if (sec_wrap) begin
                mins <= min_n;
                if (min_wrap) begin
                    hour <= hour_n;
                    if (hour_wrap) day <= day_n;
                end
                if (hit) flag <= 1'b1;
            end
        end else if (wr_go) begin
            case (wr_addr)
                A_CTRL: begin
                    run     <= wr_data[0];
                    en_min  <= wr_data[1];
                    en_hour <= wr_data[2];
                    en_day  <= wr_data[3];
                    ien     <= wr_data[4];
                    if (wr_data[5]) flag <= 1'b0;
                end
                A_SEC:    sec        <= wr_data;
                A_MIN:    mins       <= wr_data;
                A_HOUR:   hour       <= wr_data;
                A_DAYLO:  day[7:0]   <= wr_data;
                A_DAYHI:  day        <= DAY_W'({wr_data, day[7:0]});
                A_AMIN:   al_min     <= wr_data;
                A_AHOUR:  al_hour    <= wr_data;
                A_ADAYLO: al_day[7:0] <= wr_data;
                A_ADAYHI: al_day     <= DAY_W'({wr_data, al_day[7:0]});
                default: ;
            endcase
        end
    end

    assign day16    = 16'(day);
    assign al_day16 = 16'(al_day);
    assign irq      = flag & ien;

    always_comb begin
        case (addr)
            A_CTRL:   rdata = {busy, 1'b0, flag, ien, en_day, en_hour, en_min, run};
            A_SEC:    rdata = sec;
            A_MIN:    rdata = mins;
            A_HOUR:   rdata = hour;
            A_DAYLO:  rdata = day16[7:0];
            A_DAYHI:  rdata = day16[15:8];
            A_AMIN:   rdata = al_min;
            A_AHOUR:  rdata = al_hour;
            A_ADAYLO: rdata = al_day16[7:0];
            A_ADAYHI: rdata = al_day16[15:8];
            default:  rdata = 8'h00;
        endcase
    end

    AST_SEC_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sec == 8'h59) |=> (sec == 8'h00)) else $error("seconds roll"); // R1
    AST_HOUR_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sec == 8'h59 && mins == 8'h59 && hour == 8'h23) |=> (hour == 8'h00))
        else $error("hour roll"); // R2
    AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sec == 8'h59 && mins == 8'h59 && hour == 8'h23 && (&day)) |=> (day == '0))
        else $error("day wrap"); // R3
    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(busy)) else $error("flag set outside update"); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_go) |=> flag) else $error("flag dropped"); // R9
endmodule

// File: tb/bcd_rtc_tb_top.sv
module bcd_rtc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;
    int total = 0;
    int bad   = 0;
    logic [7:0] v;
    logic [7:0] cfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_rtc #(.TICKS_PER_SEC(TPS), .DAY_W(15)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [7:0] bcd(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic one_sec();
        for (int i = 0; i < TPS; i++) pulse();
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m,
                            input logic [7:0] s, input logic [15:0] d);
        wr(4'd3, h); wr(4'd2, m); wr(4'd4, d[7:0]); wr(4'd5, d[15:8]); wr(4'd1, s);
    endtask

    task automatic set_alarm(input logic [7:0] h, input logic [7:0] m, input logic [15:0] d);
        wr(4'd7, h); wr(4'd6, m); wr(4'd8, d[7:0]); wr(4'd9, d[15:8]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v); chk("R10 reset read", v, 8'h00);
        end
        total++; if (irq !== 1'b0) begin bad++; $display("FAIL R10 irq got=%b exp=0", irq); end

        cfg = 8'h01;
        wr(4'd0, cfg);
        // R10 control bit 6 and upper addresses
        wr(4'd0, 8'hDF); rd(4'd0, v); chk("R10 ctrl bit6", v, 8'h1F);
        wr(4'd12, 8'hAA); rd(4'd12, v); chk("R10 unused addr", v, 8'h00);
        wr(4'd0, cfg);

        // R1 seconds sweep
        for (int s = 0; s < 60; s++) begin
            wr(4'd2, 8'h00); wr(4'd1, bcd(s));
            one_sec();
            rd(4'd1, v); chk("R1 sec step", v, bcd((s + 1) % 60));
            rd(4'd2, v); chk("R1 sec carry", v, (s == 59) ? 8'h01 : 8'h00);
        end
        // R1 minutes sweep
        for (int m = 0; m < 60; m++) begin
            wr(4'd3, 8'h05); wr(4'd2, bcd(m)); wr(4'd1, 8'h59);
            one_sec();
            rd(4'd2, v); chk("R1 min step", v, bcd((m + 1) % 60));
            rd(4'd3, v); chk("R1 min carry", v, (m == 59) ? 8'h06 : 8'h05);
        end
        // R2 hours sweep
        for (int h = 0; h < 24; h++) begin
            set_time(bcd(h), 8'h59, 8'h59, 16'h0010);
            one_sec();
            rd(4'd3, v); chk("R2 hour step", v, bcd((h + 1) % 24));
            rd(4'd4, v); chk("R2 day carry", v, (h == 23) ? 8'h11 : 8'h10);
        end
        // R3 byte carry and wrap
        set_time(8'h23, 8'h59, 8'h59, 16'h00FF);
        one_sec();
        rd(4'd4, v); chk("R3 lo after carry", v, 8'h00);
        rd(4'd5, v); chk("R3 hi after carry", v, 8'h01);
        set_time(8'h23, 8'h59, 8'h59, 16'h7FFF);
        one_sec();
        rd(4'd4, v); chk("R3 wrap lo", v, 8'h00);
        rd(4'd5, v); chk("R3 wrap hi", v, 8'h00);
        wr(4'd5, 8'hFF); rd(4'd5, v); chk("R3 hi bit7", v, 8'h7F);

        // R4 run clear freezes time
        wr(4'd1, 8'h12); wr(4'd0, 8'h00);
        one_sec(); one_sec();
        rd(4'd1, v); chk("R4 frozen", v, 8'h12);
        wr(4'd0, cfg);
        one_sec();
        rd(4'd1, v); chk("R4 running", v, 8'h13);

        // R5 phase restart
        pulse(); pulse();
        wr(4'd1, 8'h10);
        for (int i = 0; i < TPS - 1; i++) pulse();
        rd(4'd1, v); chk("R5 not yet", v, 8'h10);
        pulse();
        rd(4'd1, v); chk("R5 full second", v, 8'h11);

        // R6 busy timing
        wr(4'd1, 8'h05);
        for (int i = 0; i < TPS - 1; i++) pulse();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        rd(4'd0, v); chk("R6 busy low after E", v & 8'h80, 8'h00);
        @(negedge clk);
        rd(4'd0, v); chk("R6 busy high", v & 8'h80, 8'h80);
        rd(4'd1, v); chk("R6 sec not yet", v, 8'h05);
        @(negedge clk);
        rd(4'd0, v); chk("R6 busy low again", v & 8'h80, 8'h00);
        rd(4'd1, v); chk("R6 sec updated", v, 8'h06);

        // R7 write in the busy cycle (collision with minute carry)
        wr(4'd2, 8'h14); wr(4'd1, 8'h59);
        for (int i = 0; i < TPS - 1; i++) pulse();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
        rd(4'd0, v); chk("R7 in busy", v & 8'h80, 8'h80);
        wr_en = 1'b1; addr = 4'd2; wdata = 8'h33;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        rd(4'd2, v); chk("R7 deferred write kept", v, 8'h33);
        rd(4'd1, v); chk("R7 update applied", v, 8'h00);

        // R8 full match with irq
        cfg = 8'h1F; wr(4'd0, cfg);
        set_alarm(8'h03, 8'h10, 16'h0005);
        set_time(8'h03, 8'h09, 8'h59, 16'h0005);
        one_sec();
        rd(4'd0, v); chk("R8 flag on match", v & 8'h20, 8'h20);
        total++; if (irq !== 1'b1) begin bad++; $display("FAIL R9 irq got=%b exp=1", irq); end
        // R9 write 0 keeps, write 1 clears
        wr(4'd0, cfg); rd(4'd0, v); chk("R9 write0 keeps", v & 8'h20, 8'h20);
        wr(4'd0, cfg | 8'h20); rd(4'd0, v); chk("R9 w1c", v & 8'h20, 8'h00);
        total++; if (irq !== 1'b0) begin bad++; $display("FAIL R9 irq clear got=%b exp=0", irq); end
        // R8 hour mismatch
        wr(4'd7, 8'h04);
        set_time(8'h03, 8'h09, 8'h59, 16'h0005);
        one_sec();
        rd(4'd0, v); chk("R8 mismatch no flag", v & 8'h20, 8'h00);
        // R8 hour disabled -> ignored
        cfg = 8'h1B; wr(4'd0, cfg);
        set_time(8'h03, 8'h09, 8'h59, 16'h0005);
        one_sec();
        rd(4'd0, v); chk("R8 disabled field ignored", v & 8'h20, 8'h20);
        wr(4'd0, cfg | 8'h20);
        // R8 no rollover to 00 -> no flag
        cfg = 8'h13; wr(4'd0, cfg);
        set_time(8'h03, 8'h10, 8'h29, 16'h0005);
        one_sec();
        rd(4'd0, v); chk("R8 no roll no flag", v & 8'h20, 8'h00);
        // R8 day match across carry with hour/minute
        cfg = 8'h1F; wr(4'd0, cfg);
        set_alarm(8'h00, 8'h00, 16'h0123);
        set_time(8'h23, 8'h59, 8'h59, 16'h0122);
        one_sec();
        rd(4'd0, v); chk("R8 day match", v & 8'h20, 8'h20);
        wr(4'd0, cfg | 8'h20);
        // R9 irq masked
        cfg = 8'h01; wr(4'd0, cfg);
        set_time(8'h01, 8'h01, 8'h59, 16'h0000);
        one_sec();
        rd(4'd0, v); chk("R8 no enables every minute", v & 8'h20, 8'h20);
        total++; if (irq !== 1'b0) begin bad++; $display("FAIL R9 masked irq got=%b exp=0", irq); end
        // R8 alarm readback
        rd(4'd8, v); chk("R8 alarm day lo", v, 8'h23);
        rd(4'd9, v); chk("R8 alarm day hi", v, 8'h01);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule